// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial non-volatile memory of 64 words, each 16 bits wide. A host drives it through four wires: chip select, serial clock, serial data in and serial data out. The serial data out pin is modelled as a value plus an output enable, so the surrounding logic can build a tri-state pad or a bus mux from it. All four pins are brought into the system clock domain through synchronisers, and every serial clock rising edge and chip-select falling edge is detected there.

An instruction starts with a 1, followed by a two-bit opcode and a six-bit address, MSB first. Read streams a word back; write, erase and their whole-array forms change the array; two more commands lock and unlock programming. A programming command only takes effect when chip select falls after the complete instruction. That edge starts a self-timed busy period counted in system clocks. While the period runs, a host that raises chip select sees the data-out pin report busy (0) and then ready (1).

Top module: `serial_nvm_model`

## Requirements
- R1: After reset the data-out enable is 0, programming is locked, and every word holds 16'hFFFF.
- R2: An instruction is framed by chip select high and sampled on serial clock rising edges: start bit 1, opcode (2 bits), address (6 bits), MSB first. Zero bits before the start bit, and rising edges while chip select is low, have no effect.
- R3: Opcode 10 reads the addressed word: data-out is enabled and shows a 0 first, then the 16 data bits MSB first, each one advanced by a serial clock rising edge. Read works whether programming is locked or not.
- R4: Opcode 01 takes 16 further data bits, MSB first. The stored word becomes the old word AND the new data.
- R5: Opcode 11 sets the addressed word to 16'hFFFF. Opcode 00 with address bits [5:4] = 10 sets every word to 16'hFFFF.
- R6: Opcode 00 with address bits [5:4] = 01 takes 16 data bits and ANDs them into every word.
- R7: Opcode 00 with address bits [5:4] = 11 unlocks programming; with 00 it locks it. While locked, the four programming commands leave the array unchanged and start no busy period.
- R8: A programming command takes effect on the chip-select falling edge after its last bit and starts a busy period of PROG_CYCLES system clocks, during which the array does not change. A chip-select fall before the last bit abandons the command.
- R9: With chip select high during the busy period, data-out is enabled and drives 0. Serial clocks in that period are ignored. Once the period ends with chip select high, data-out drives 1 until chip select falls.
- R10: At all other times the data-out enable is 0. Every output responds three system clocks after the input pin change that causes it: two synchroniser stages plus one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value, 0 when not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial data out pin |

## Verification
Every output change is due three system clocks after the pin edge that causes it. The bench therefore runs its reference model on the raw pins, delays the model's outputs by two clocks, and compares them with the design on the falling edge of every clock. The host tasks give each serial clock phase four system clocks. Read bits are sampled eight clocks after the rising edge that advanced them, and status is sampled six clocks after chip select rises. Both points sit well past the three-clock latency. The bench waits PROG_CYCLES plus ten clocks before it expects the ready value, so the busy-to-ready change is settled when it is sampled.

// File: rtl/nvm_pkg.sv
// Shared types for the serial memory model: protocol states and the kinds
// of array update. Assumes nothing beyond a 3-bit encoding for each.
package nvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_WAIT,
        ST_BUSY,
        ST_DONE
    } fsm_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WRITE,
        OP_ERASE,
        OP_ERASE_ALL,
        OP_WRITE_ALL
    } prog_op_e;

endpackage

// File: rtl/nvm_pin_sync.sv
// Multi-stage synchroniser for one asynchronous input pin.
// Assumes STAGES >= 2; the output lags the pin by STAGES clocks.
module nvm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin value through the flip-flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvm_busy_timer.sv
// Self-timed programming period. A start pulse arms a down-counter; done_o
// is high in the last of CYCLES running cycles. Assumes CYCLES >= 1.
module nvm_busy_timer #(
    parameter int CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // Load on start, then count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= CW'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = run_q && (cnt_q == '0);

endmodule

// File: rtl/nvm_word_array.sv
// Flip-flop register file. Applies one update on a go pulse: single-word
// AND-write or erase, or the whole-array forms. Reset leaves every bit at 1.
// Assumes addr_i is below WORDS when a single-word op is issued.
module nvm_word_array
    import nvm_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go_i,
    input  prog_op_e               op_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [WIDTH-1:0]       wdata_i,
    output logic [WORDS*WIDTH-1:0] mem_o
);

    for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
        logic [WIDTH-1:0] word_q;
        logic             hit;

        assign hit = (addr_i == ADDR_W'(gi));

        // Update this word when the pending operation targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '1;
            end else if (go_i) begin
                case (op_i)
                    OP_WRITE:     if (hit) word_q <= word_q & wdata_i;
                    OP_ERASE:     if (hit) word_q <= '1;
                    OP_ERASE_ALL: word_q <= '1;
                    OP_WRITE_ALL: word_q <= word_q & wdata_i;
                    default:      word_q <= word_q;
                endcase
            end
        end

        assign mem_o[gi*WIDTH +: WIDTH] = word_q;
    end

endmodule

// File: rtl/serial_nvm_model.sv
// Serial memory slave: synchronises the four pins, frames and decodes the
// 9-bit instructions, streams read data, holds the programming lock, and
// sequences the self-timed busy period with status on data-out.
// Assumes the serial clock is slow enough that every phase spans more than
// SYNC_STAGES + 1 system clocks, and that 2 + log2(WORDS) <= WIDTH.
module serial_nvm_model
    import nvm_pkg::*;
#(
    parameter int WORDS       = 64,
    parameter int WIDTH       = 16,
    parameter int PROG_CYCLES = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    localparam int ADDR_W     = $clog2(WORDS);
    localparam int INSTR_BITS = 2 + ADDR_W;
    localparam int CNT_W      = $clog2(WIDTH + INSTR_BITS);

    logic cs_s, sck_s, sdi_s;
    logic cs_d_q, sck_d_q;
    logic sck_rise;

    nvm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_cs  (.clk(clk), .rst_n(rst_n), .pin_i(cs_i),  .sync_o(cs_s));
    nvm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sck (.clk(clk), .rst_n(rst_n), .pin_i(sck_i), .sync_o(sck_s));
    nvm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sdi (.clk(clk), .rst_n(rst_n), .pin_i(sdi_i), .sync_o(sdi_s));

    // Keep the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d_q  <= 1'b0;
            sck_d_q <= 1'b0;
        end else begin
            cs_d_q  <= cs_s;
            sck_d_q <= sck_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d_q;

    fsm_e                   state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [WIDTH-1:0]       shin_q;
    logic [ADDR_W-1:0]      addr_q;
    prog_op_e               op_q;
    logic                   pend_q;
    logic                   prog_en_q;
    logic [WIDTH-1:0]       rdsh_q;
    logic                   rdbit_q;

    logic [INSTR_BITS-1:0]  instr;
    logic [1:0]             opc;
    logic [ADDR_W-1:0]      iaddr;
    logic [1:0]             sub;
    logic [WORDS*WIDTH-1:0] mem_flat;
    logic [WIDTH-1:0]       word_rd;
    logic                   prog_go;
    logic                   tmr_done;

    // Decode view of the instruction including the bit arriving now.
    always_comb begin
        instr   = {shin_q[INSTR_BITS-2:0], sdi_s};
        opc     = instr[INSTR_BITS-1 -: 2];
        iaddr   = instr[ADDR_W-1:0];
        sub     = iaddr[ADDR_W-1 -: 2];
        word_rd = mem_flat[iaddr*WIDTH +: WIDTH];
    end

    assign prog_go = (state_q == ST_WAIT) && !cs_s && pend_q;

    nvm_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (prog_go),
        .op_i   (op_q),
        .addr_i (addr_q),
        .wdata_i(shin_q),
        .mem_o  (mem_flat)
    );

    nvm_busy_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(prog_go),
        .done_o (tmr_done)
    );

    // Protocol sequencer: framing, decode, data capture, read shift, busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            shin_q    <= '0;
            addr_q    <= '0;
            op_q      <= OP_NONE;
            pend_q    <= 1'b0;
            prog_en_q <= 1'b0;
            rdsh_q    <= '0;
            rdbit_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cs_s && sck_rise && sdi_s) begin
                        state_q <= ST_CMD;
                        cnt_q   <= '0;
                    end
                end
                ST_CMD: begin
                    if (!cs_s) begin
                        state_q <= ST_IDLE;
                    end else if (sck_rise) begin
                        shin_q <= {shin_q[WIDTH-2:0], sdi_s};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(INSTR_BITS - 1)) begin
                            addr_q <= iaddr;
                            cnt_q  <= '0;
                            pend_q <= 1'b0;
                            case (opc)
                                2'b10: begin
                                    state_q <= ST_READ;
                                    rdsh_q  <= word_rd;
                                    rdbit_q <= 1'b0;
                                end
                                2'b01: begin
                                    op_q    <= OP_WRITE;
                                    state_q <= ST_DATA;
                                end
                                2'b11: begin
                                    op_q    <= OP_ERASE;
                                    pend_q  <= prog_en_q;
                                    state_q <= ST_WAIT;
                                end
                                default: begin
                                    case (sub)
                                        2'b11: begin
                                            prog_en_q <= 1'b1;
                                            state_q   <= ST_WAIT;
                                        end
                                        2'b00: begin
                                            prog_en_q <= 1'b0;
                                            state_q   <= ST_WAIT;
                                        end
                                        2'b10: begin
                                            op_q    <= OP_ERASE_ALL;
                                            pend_q  <= prog_en_q;
                                            state_q <= ST_WAIT;
                                        end
                                        default: begin
                                            op_q    <= OP_WRITE_ALL;
                                            state_q <= ST_DATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_DATA: begin
                    if (!cs_s) begin
                        state_q <= ST_IDLE;
                    end else if (sck_rise) begin
                        shin_q <= {shin_q[WIDTH-2:0], sdi_s};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CNT_W'(WIDTH - 1)) begin
                            pend_q  <= prog_en_q;
                            state_q <= ST_WAIT;
                        end
                    end
                end
                ST_READ: begin
                    if (!cs_s) begin
                        state_q <= ST_IDLE;
                    end else if (sck_rise) begin
                        rdbit_q <= rdsh_q[WIDTH-1];
                        rdsh_q  <= {rdsh_q[WIDTH-2:0], 1'b0};
                    end
                end
                ST_WAIT: begin
                    if (!cs_s) begin
                        state_q <= pend_q ? ST_BUSY : ST_IDLE;
                        pend_q  <= 1'b0;
                    end
                end
                ST_BUSY: begin
                    if (tmr_done) state_q <= cs_s ? ST_DONE : ST_IDLE;
                end
                ST_DONE: begin
                    if (!cs_s) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Data-out: read stream, or busy/ready status while chip select is high.
    always_comb begin
        sdo_oe_o = (state_q == ST_READ) ||
                   (((state_q == ST_BUSY) || (state_q == ST_DONE)) && cs_d_q);
        sdo_o    = sdo_oe_o && ((state_q == ST_READ) ? rdbit_q : (state_q == ST_DONE));
    end

endmodule

// File: rtl/serial_nvm_model_chk.sv
// Property checker for serial_nvm_model, attached by bind below.
// Observes the sequencer state, the lock, the array image and data-out.
module serial_nvm_model_chk
    import nvm_pkg::*;
#(
    parameter int WORDS = 64,
    parameter int WIDTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input fsm_e                   state_q,
    input logic                   prog_en_q,
    input logic                   cs_d_q,
    input logic [WORDS*WIDTH-1:0] mem_flat,
    input logic                   sdo_o,
    input logic                   sdo_oe_o
);

    // R10: no drive while waiting for an instruction.
    a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sdo_oe_o);

    // R9: busy status drives 0 while chip select is high.
    a_r9_busy_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cs_d_q) |-> (sdo_oe_o && !sdo_o));

    // R3: the first bit of a read is a driven 0.
    a_r3_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) != ST_READ) |-> (sdo_oe_o && !sdo_o));

    // R7: a busy period only begins while programming is unlocked.
    a_r7_busy_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && $past(state_q) == ST_WAIT) |-> prog_en_q);

    // R8: the array holds still during the busy period.
    a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY) |=> $stable(mem_flat));

    // R8: the array changes only as the busy period starts.
    a_r8_change_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_flat) |-> (state_q == ST_BUSY && $past(state_q) == ST_WAIT));

endmodule

bind serial_nvm_model serial_nvm_model_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .prog_en_q(prog_en_q),
    .cs_d_q   (cs_d_q),
    .mem_flat (mem_flat),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
);

// File: tb/serial_nvm_model_bench.sv
// Bench: host tasks drive the pins; a behavioural reference model runs on
// the raw pins and is compared (two clocks delayed) on every clock.
module serial_nvm_model_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 40;
    localparam int LAT        = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic sdo, sdo_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit run_cmp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_nvm_model #(.PROG_CYCLES(PROG)) u_serial_nvm_model (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(di),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_st, m_n, m_cmd, m_dat, m_addr, m_kind, m_left, m_sh, m_out;
    bit m_en, m_pend, pv_sck, pv_cs;
    int m_mem [64];
    bit h_oe [LAT+1];
    bit h_v  [LAT+1];

    function automatic void m_apply();
        for (int w = 0; w < 64; w++) begin
            if (m_kind == 1 && w == m_addr) m_mem[w] = m_mem[w] & m_dat;
            if (m_kind == 2 && w == m_addr) m_mem[w] = 'hFFFF;
            if (m_kind == 3) m_mem[w] = 'hFFFF;
            if (m_kind == 4) m_mem[w] = m_mem[w] & m_dat;
        end
    endfunction

    always @(posedge clk) begin
        bit rise, oe, v;
        if (!rst_n) begin
            m_st = 0; m_n = 0; m_cmd = 0; m_dat = 0; m_en = 0; m_pend = 0;
            m_left = 0; m_out = 0; m_sh = 0; pv_sck = 0; pv_cs = 0;
            for (int w = 0; w < 64; w++) m_mem[w] = 'hFFFF;
        end else begin
            rise = sck && !pv_sck;
            case (m_st)
                0: if (cs && rise && di) begin m_st = 1; m_n = 0; m_cmd = 0; end
                1: if (!cs) m_st = 0;
                   else if (rise) begin
                       m_cmd = m_cmd * 2 + int'(di);
                       m_n++;
                       if (m_n == 8) begin
                           m_addr = m_cmd & 63; m_pend = 0; m_n = 0;
                           case ((m_cmd >> 6) & 3)
                               2: begin m_st = 3; m_sh = m_mem[m_addr]; m_out = 0; end
                               1: begin m_kind = 1; m_st = 2; m_dat = 0; end
                               3: begin m_kind = 2; m_pend = m_en; m_st = 4; end
                               default: case (m_addr >> 4)
                                   3: begin m_en = 1; m_st = 4; end
                                   0: begin m_en = 0; m_st = 4; end
                                   2: begin m_kind = 3; m_pend = m_en; m_st = 4; end
                                   default: begin m_kind = 4; m_st = 2; m_dat = 0; end
                               endcase
                           endcase
                       end
                   end
                2: if (!cs) m_st = 0;
                   else if (rise) begin
                       m_dat = ((m_dat << 1) | int'(di)) & 'hFFFF;
                       m_n++;
                       if (m_n == 16) begin m_pend = m_en; m_st = 4; end
                   end
                3: if (!cs) m_st = 0;
                   else if (rise) begin
                       m_out = (m_sh >> 15) & 1;
                       m_sh = (m_sh << 1) & 'hFFFF;
                   end
                4: if (!cs) begin
                       if (m_pend) begin m_apply(); m_st = 5; m_left = PROG; end
                       else m_st = 0;
                       m_pend = 0;
                   end
                5: begin
                       m_left--;
                       if (m_left == 0) m_st = cs ? 6 : 0;
                   end
                default: if (!cs) m_st = 0;
            endcase
            pv_sck = sck;
            pv_cs = cs;
        end
        oe = (m_st == 3) || ((m_st == 5 || m_st == 6) && cs && rst_n);
        v  = oe && ((m_st == 3) ? (m_out != 0) : (m_st == 6));
        for (int k = LAT; k > 0; k--) begin h_oe[k] = h_oe[k-1]; h_v[k] = h_v[k-1]; end
        h_oe[0] = oe;
        h_v[0]  = v;
    end

    // Per-clock comparison against the delayed model (R10 covers timing).
    always @(negedge clk) begin
        if (rst_n && run_cmp && !finished) begin
            check("R10", 32'(sdo_oe), 32'(h_oe[LAT]), "per-clock enable");
            if (h_oe[LAT]) check("R10", 32'(sdo), 32'(h_v[LAT]), "per-clock value");
        end
    end

    // ---------------- host tasks ----------------
    task automatic clk_wait(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_bit(bit b);
        di = b; clk_wait(4);
        sck = 1'b1; clk_wait(4);
        sck = 1'b0;
    endtask

    task automatic send_instr(logic [1:0] opc, logic [5:0] a);
        sck_bit(1'b1);
        for (int i = 1; i >= 0; i--) sck_bit(opc[i]);
        for (int i = 5; i >= 0; i--) sck_bit(a[i]);
    endtask

    task automatic do_read(string tag, logic [5:0] a, logic [15:0] exp, int lead);
        logic [15:0] w = '0;
        cs = 1'b1; clk_wait(4);
        for (int i = 0; i < lead; i++) sck_bit(1'b0);
        send_instr(2'b10, a);
        for (int i = 0; i <= 16; i++) begin
            clk_wait(4);
            if (i == 0) begin
                check(tag, 32'(sdo_oe), 1, "enable at dummy bit");
                check(tag, 32'(sdo), 0, "dummy bit");
            end else begin
                w[16-i] = sdo;
            end
            sck = 1'b1; clk_wait(4); sck = 1'b0;
        end
        check(tag, 32'(w), 32'(exp), "read word");
        cs = 1'b0; clk_wait(6);
    endtask

    task automatic prog(logic [1:0] opc, logic [5:0] a, bit has_data, logic [15:0] d);
        cs = 1'b1; clk_wait(4);
        send_instr(opc, a);
        if (has_data) for (int i = 15; i >= 0; i--) sck_bit(d[i]);
        clk_wait(2);
        cs = 1'b0; clk_wait(PROG + 10);
    endtask

    task automatic expect_quiet(string tag);
        cs = 1'b1; clk_wait(6);
        check(tag, 32'(sdo_oe), 0, "no status drive");
        cs = 1'b0; clk_wait(6);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        clk_wait(5);
        rst_n = 1'b1;
        clk_wait(4);
        run_cmp = 1;
        check("R1", 32'(sdo_oe), 0, "enable after reset");
        do_read("R1", 6'd5, 16'hFFFF, 0);
        do_read("R3", 6'd63, 16'hFFFF, 0);

        // Locked: write must not change the array or start a busy period.
        prog(2'b01, 6'd3, 1, 16'h1234);
        expect_quiet("R7");
        do_read("R7", 6'd3, 16'hFFFF, 0);

        prog(2'b00, 6'b110000, 0, '0);
        expect_quiet("R7");

        // Write with status observation; a stray start bit while busy is ignored.
        cs = 1'b1; clk_wait(4);
        send_instr(2'b01, 6'd3);
        for (int i = 15; i >= 0; i--) sck_bit(16'hA5C3 >> i);
        clk_wait(2);
        cs = 1'b0; clk_wait(4);
        cs = 1'b1; clk_wait(6);
        check("R9", 32'(sdo_oe), 1, "busy enable");
        check("R9", 32'(sdo), 0, "busy value");
        sck_bit(1'b1);
        check("R8", 32'(sdo), 0, "still busy");
        clk_wait(PROG + 10);
        check("R9", 32'(sdo_oe), 1, "ready enable");
        check("R9", 32'(sdo), 1, "ready value");
        cs = 1'b0; clk_wait(6);
        check("R10", 32'(sdo_oe), 0, "released after status");
        do_read("R4", 6'd3, 16'hA5C3, 0);

        prog(2'b01, 6'd3, 1, 16'h0FF0);
        do_read("R4", 6'd3, 16'h05C0, 0);

        prog(2'b11, 6'd3, 0, '0);
        do_read("R5", 6'd3, 16'hFFFF, 0);

        prog(2'b00, 6'b010000, 1, 16'h3C3C);
        do_read("R6", 6'd3, 16'h3C3C, 0);
        do_read("R6", 6'd40, 16'h3C3C, 0);

        prog(2'b00, 6'b100000, 0, '0);
        do_read("R5", 6'd63, 16'hFFFF, 0);
        do_read("R5", 6'd0, 16'hFFFF, 0);

        prog(2'b01, 6'd7, 1, 16'h1111);
        prog(2'b00, 6'b000000, 0, '0);
        prog(2'b11, 6'd7, 0, '0);
        expect_quiet("R7");
        prog(2'b00, 6'b010000, 1, 16'h0000);
        do_read("R7", 6'd7, 16'h1111, 0);
        do_read("R3", 6'd7, 16'h1111, 0);

        // Abandoned write: chip select falls after only 8 data bits.
        prog(2'b00, 6'b110000, 0, '0);
        cs = 1'b1; clk_wait(4);
        send_instr(2'b01, 6'd12);
        for (int i = 0; i < 8; i++) sck_bit(1'b0);
        cs = 1'b0; clk_wait(6);
        expect_quiet("R8");
        do_read("R8", 6'd12, 16'hFFFF, 0);

        // Leading zeros before the start bit, and clocks with chip select low.
        do_read("R2", 6'd7, 16'h1111, 3);
        sck_bit(1'b1); sck_bit(1'b1);
        check("R2", 32'(sdo_oe), 0, "clocks with chip select low");
        do_read("R2", 6'd7, 16'h1111, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule